// File: doc/BRIEF.md
# Program Counter Unit with Return Stack

This block produces the instruction fetch address for a small microcontroller core that keeps program and data memories separate. It holds a 13-bit counter that steps once per instruction cycle. The counter can instead be reloaded in five ways: through a write of its low byte, through a jump or call target taken from the instruction word, from the top of a return stack, or from the fixed interrupt address. The upper address bits are never written directly. Software first writes a 5-bit holding register, and that register supplies the high bits when a low-byte write, jump or call reloads the counter.

Call and interrupt entry save the current counter value on an 8-entry return stack, and a return restores it. The stack is a ring. A ninth nested save overwrites the oldest entry, and a restore from an empty stack returns whatever that slot still holds. Neither case is an error, but a one-cycle pulse marks every save that overwrote a live entry. The fetch address is the counter folded into the implemented memory size, so locations above that size alias onto the lower ones.

The fetch address is presented on every cycle. The memory side has no back-pressure: the core stalls the stream by holding `step_en` low. Every other pin is a plain level control that is sampled on the rising clock edge.

Top module: `pc_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `fetch_addr`, `pc_low` and `stk_wrap` are 0. The holding register also resets to 0, so a low-byte write made before any holding write gives an address with zero upper bits.
- R2: With `step_en` high and no other control active, the counter advances by 1 per cycle and rolls from 1FFFh to 0000h. With no control active it holds its value.
- R3: A low-byte write sets the counter to {hold[4:0], low_wdata[7:0]}. `pc_low` always shows counter bits 7:0.
- R4: A jump sets the counter to {hold[4:3], jump_target[10:0]}.
- R5: A call loads the same address as a jump and saves the previous counter value on the return stack.
- R6: A return loads the most recently saved value that has not yet been restored.
- R7: An interrupt request loads 0004h and saves the previous counter value on the return stack.
- R8: The stack keeps the 8 most recent saves. A ninth save overwrites the oldest one. Each restore steps back one slot around the ring, including when the stack is empty, and returns that slot's stored value.
- R9: `stk_wrap` is high for exactly the one cycle after a save that was made while 8 saves were live.
- R10: `fetch_addr` equals the counter modulo `MEM_WORDS` (1024, 2048, 4096 or 8192; default 2048).
- R11: When several controls are active, priority is interrupt, return, call, jump, low-byte write, step. A holding write in the same cycle takes effect only for later reloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Advance by one instruction |
| hold_we | input | 1 | Write the upper-bits holding register |
| hold_wdata | input | 5 | Holding register write value |
| low_we | input | 1 | Write the counter low byte |
| low_wdata | input | 8 | Low byte write value |
| jump_en | input | 1 | Jump to target |
| call_en | input | 1 | Call target, saving the return address |
| jump_target | input | 11 | Target bits 10:0 from the instruction |
| ret_en | input | 1 | Restore from the return stack |
| irq_req | input | 1 | Enter the interrupt vector |
| fetch_addr | output | 13 | Program memory fetch address |
| pc_low | output | 8 | Counter bits 7:0 for register reads |
| stk_wrap | output | 1 | Pulse: a save overwrote a live entry |

## Verification
The hardest states to reach from the ports are ring overwrite and underflow. Both need nine nested saves before any restore, and the targets must differ so that each slot can be identified. The stimulus makes ten calls in a row to distinct addresses, then makes more restores than there are slots, so that the pointer walks back past the newest entries into overwritten and stale ones. A reference model in the bench predicts every step of that walk.

// File: rtl/pc_pkg.sv
package pc_pkg;
  parameter int unsigned PC_W   = 13;
  parameter int unsigned LOW_W  = 8;
  parameter int unsigned HOLD_W = PC_W - LOW_W;
  parameter int unsigned TGT_W  = 11;
  parameter logic [PC_W-1:0] RST_VEC = '0;
  parameter logic [PC_W-1:0] IRQ_VEC = PC_W'(4);

  typedef enum logic [2:0] {
    SRC_KEEP,
    SRC_INC,
    SRC_LOW,
    SRC_TGT,
    SRC_POP,
    SRC_VEC
  } pc_src_e;
endpackage

// File: rtl/pc_next.sv
module pc_next
  import pc_pkg::*;
(
  input  logic [PC_W-1:0]   pc_i,
  input  logic [HOLD_W-1:0] hold_i,
  input  logic              step_i,
  input  logic              low_we_i,
  input  logic [LOW_W-1:0]  low_d_i,
  input  logic              jump_i,
  input  logic              call_i,
  input  logic [TGT_W-1:0]  tgt_i,
  input  logic              ret_i,
  input  logic              irq_i,
  input  logic [PC_W-1:0]   tos_i,
  output logic [PC_W-1:0]   nxt_o,
  output logic              push_o,
  output logic              pop_o
);
  localparam int unsigned PAGE_W = PC_W - TGT_W;

  pc_src_e src;

  always_comb begin
    if (irq_i)         src = SRC_VEC;
    else if (ret_i)    src = SRC_POP;
    else if (call_i || jump_i) src = SRC_TGT;
    else if (low_we_i) src = SRC_LOW;
    else if (step_i)   src = SRC_INC;
    else               src = SRC_KEEP;
  end

  always_comb begin
    unique case (src)
      SRC_VEC:  nxt_o = IRQ_VEC;
      SRC_POP:  nxt_o = tos_i;
      SRC_TGT:  nxt_o = {hold_i[HOLD_W-1 -: PAGE_W], tgt_i};
      SRC_LOW:  nxt_o = {hold_i, low_d_i};
      SRC_INC:  nxt_o = pc_i + PC_W'(1);
      default:  nxt_o = pc_i;
    endcase
  end

  assign push_o = irq_i || (!ret_i && call_i);
  assign pop_o  = !irq_i && ret_i;
endmodule

// File: rtl/pc_stack.sv
module pc_stack #(
  parameter int unsigned W     = 13,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] tos_o,
  output logic         wrap_o
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] sp_q;
  logic [CW-1:0] live_q;
  logic          full;

  assign full  = (live_q == CW'(DEPTH));
  assign tos_o = slot_q[sp_q - PW'(1)];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              slot_q[g] <= '0;
      else if (push_i && sp_q == PW'(g))       slot_q[g] <= din_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q   <= '0;
      live_q <= '0;
      wrap_o <= 1'b0;
    end else begin
      wrap_o <= push_i && full;
      if (push_i) begin
        sp_q <= sp_q + PW'(1);
        if (!full) live_q <= live_q + CW'(1);
      end else if (pop_i) begin
        sp_q <= sp_q - PW'(1);
        if (live_q != '0) live_q <= live_q - CW'(1);
      end
    end
  end
endmodule

// File: rtl/pc_unit.sv
module pc_unit #(
  parameter int unsigned MEM_WORDS = 2048,
  parameter int unsigned STK_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step_en,
  input  logic        hold_we,
  input  logic [4:0]  hold_wdata,
  input  logic        low_we,
  input  logic [7:0]  low_wdata,
  input  logic        jump_en,
  input  logic        call_en,
  input  logic [10:0] jump_target,
  input  logic        ret_en,
  input  logic        irq_req,
  output logic [12:0] fetch_addr,
  output logic [7:0]  pc_low,
  output logic        stk_wrap
);
  import pc_pkg::*;

  localparam int unsigned AW = $clog2(MEM_WORDS);
  localparam logic [PC_W-1:0] FOLD = PC_W'(MEM_WORDS - 1);

  logic [PC_W-1:0]   pc_q, pc_d, tos;
  logic [HOLD_W-1:0] hold_q;
  logic              push, pop;

  pc_next i_next (
    .pc_i     (pc_q),
    .hold_i   (hold_q),
    .step_i   (step_en),
    .low_we_i (low_we),
    .low_d_i  (low_wdata),
    .jump_i   (jump_en),
    .call_i   (call_en),
    .tgt_i    (jump_target),
    .ret_i    (ret_en),
    .irq_i    (irq_req),
    .tos_i    (tos),
    .nxt_o    (pc_d),
    .push_o   (push),
    .pop_o    (pop)
  );

  pc_stack #(.W(PC_W), .DEPTH(STK_DEPTH)) i_stack (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (push),
    .pop_i  (pop),
    .din_i  (pc_q),
    .tos_o  (tos),
    .wrap_o (stk_wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= RST_VEC;
      hold_q <= '0;
    end else begin
      pc_q <= pc_d;
      if (hold_we) hold_q <= hold_wdata;
    end
  end

  if (AW >= PC_W) begin : g_full
    assign fetch_addr = pc_q;
  end else begin : g_fold
    assign fetch_addr = pc_q & FOLD;
  end

  assign pc_low = pc_q[LOW_W-1:0];
endmodule

// File: rtl/pc_unit_chk.sv
module pc_unit_chk #(
  parameter int unsigned MEM_WORDS = 2048
) (
  input logic        clk,
  input logic        rst_n,
  input logic        step_en,
  input logic        low_we,
  input logic [7:0]  low_wdata,
  input logic        jump_en,
  input logic        call_en,
  input logic [10:0] jump_target,
  input logic        ret_en,
  input logic        irq_req,
  input logic [12:0] fetch_addr,
  input logic [7:0]  pc_low,
  input logic        stk_wrap
);
  localparam logic [12:0] FOLD = 13'(MEM_WORDS - 1);

  logic quiet;
  assign quiet = !irq_req && !ret_en && !call_en && !jump_en && !low_we;

  // R2
  step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && step_en) |=> fetch_addr == (($past(fetch_addr) + 13'd1) & FOLD));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !step_en) |=> $stable(fetch_addr));

  // R3
  low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (low_we && !irq_req && !ret_en && !call_en && !jump_en) |=> pc_low == $past(low_wdata));

  // R4
  jump_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((jump_en || call_en) && !irq_req && !ret_en) |=> pc_low == $past(jump_target[7:0]));

  // R7
  irq_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> fetch_addr == 13'h0004);

  // R9
  wrap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_wrap |-> $past(irq_req || (call_en && !ret_en)));
endmodule

bind pc_unit pc_unit_chk #(.MEM_WORDS(MEM_WORDS)) i_chk (
  .clk(clk), .rst_n(rst_n), .step_en(step_en), .low_we(low_we),
  .low_wdata(low_wdata), .jump_en(jump_en), .call_en(call_en),
  .jump_target(jump_target), .ret_en(ret_en), .irq_req(irq_req),
  .fetch_addr(fetch_addr), .pc_low(pc_low), .stk_wrap(stk_wrap)
);

// File: tb/test_pc_unit.sv
module test_pc_unit;
  localparam int MEMW = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_en = 0, hold_we = 0, low_we = 0, jump_en = 0, call_en = 0;
  logic        ret_en = 0, irq_req = 0;
  logic [4:0]  hold_wdata = '0;
  logic [7:0]  low_wdata = '0;
  logic [10:0] jump_target = '0;
  logic [12:0] fetch_addr;
  logic [7:0]  pc_low;
  logic        stk_wrap;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  pc_unit #(.MEM_WORDS(MEMW), .STK_DEPTH(8)) i_pc_unit (.*);

  // reference model state
  logic [12:0] m_pc = '0;
  logic [4:0]  m_hold = '0;
  logic [12:0] m_stk [8];
  logic [2:0]  m_sp = '0;
  int          m_live = 0;

  logic [21:0] exp_q [$];
  string       tag_q [$];

  task automatic check(string tag, logic [21:0] got, logic [21:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got wrap=%0b low=%02h addr=%04h, expected wrap=%0b low=%02h addr=%04h",
               tag, got[21], got[20:13], got[12:0], exp[21], exp[20:13], exp[12:0]);
    end
  endtask

  // driver: one operation per cycle, expectation queued for the monitor
  task automatic op(string tag, bit st, bit hw, logic [4:0] hd, bit lw, logic [7:0] ld,
                    bit jp, bit cl, logic [10:0] tg, bit rt, bit iq);
    logic [12:0] nxt;
    bit push, wrap;
    @(negedge clk);
    step_en = st; hold_we = hw; hold_wdata = hd; low_we = lw; low_wdata = ld;
    jump_en = jp; call_en = cl; jump_target = tg; ret_en = rt; irq_req = iq;
    push = 0;
    nxt = m_pc;
    if (iq) begin nxt = 13'h0004; push = 1; end
    else if (rt) nxt = m_stk[m_sp - 3'd1];
    else if (cl || jp) begin nxt = {m_hold[4:3], tg}; push = cl; end
    else if (lw) nxt = {m_hold, ld};
    else if (st) nxt = m_pc + 13'd1;
    wrap = push && (m_live == 8);
    if (push) begin
      m_stk[m_sp] = m_pc; m_sp = m_sp + 3'd1;
      if (m_live < 8) m_live++;
    end else if (rt) begin
      m_sp = m_sp - 3'd1;
      if (m_live > 0) m_live--;
    end
    if (hw) m_hold = hd;
    m_pc = nxt;
    exp_q.push_back({wrap, nxt[7:0], nxt & 13'(MEMW - 1)});
    tag_q.push_back(tag);
  endtask

  task automatic idle(string tag);
    op(tag, 0, 0, 5'd0, 0, 8'd0, 0, 0, 11'd0, 0, 0);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0)
        check(tag_q.pop_front(), {stk_wrap, pc_low, fetch_addr}, exp_q.pop_front());
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_stk[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset", {stk_wrap, pc_low, fetch_addr}, '0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after reset", {stk_wrap, pc_low, fetch_addr}, '0);

    op("R1 R3 hold reset zero", 0, 0, 0, 1, 8'h34, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) op("R2 step", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    idle("R2 hold when idle");
    op("R11 hold write same cycle", 0, 1, 5'h1F, 1, 8'hFF, 0, 0, 0, 0, 0);
    op("R3 R10 low write folds", 0, 0, 0, 1, 8'hFE, 0, 0, 0, 0, 0);
    op("R2 R10 step", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    op("R2 rollover", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    op("R4 jump page bits", 0, 0, 0, 0, 0, 1, 0, 11'h123, 0, 0);
    op("R11 jump over step", 1, 0, 0, 0, 0, 1, 0, 11'h0AA, 0, 0);
    op("R5 call", 0, 0, 0, 0, 0, 0, 1, 11'h050, 0, 0);
    op("R6 return", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    op("R7 R11 irq over call", 0, 0, 0, 0, 0, 0, 1, 11'h111, 0, 1);
    op("R6 return from irq", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    op("R11 return over call", 0, 0, 0, 0, 0, 0, 1, 11'h222, 1, 0);
    op("R11 hold change", 0, 1, 5'h08, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 10; i++)
      op("R8 R9 nested call", 0, 0, 0, 0, 0, 0, 1, 11'(16 * i + 3), 0, 0);
    idle("R9 pulse clears");
    for (int i = 0; i < 11; i++) op("R6 R8 unwind", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    op("R7 irq vector", 1, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    op("R9 no wrap after drain", 0, 0, 0, 0, 0, 0, 1, 11'h3FF, 0, 0);
    idle("R2 final");
    repeat (3) @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule